// File: doc/BRIEF.md
# Edge-capturing pin I/O controller

This block is a register-mapped controller for a bank of 28 general-purpose pins. Software reads the synchronized level of every pin, picks a direction per pin and drives output pins from an output latch. The latch is never written as a whole word. One register sets latch bits and another clears them, so two agents can change different pins without a read-modify-write.

Each pin can record a rising transition, a falling transition, or both, into a sticky event register. Software acknowledges an event by writing a one to its bit. The event bits of the low eleven pins each drive a dedicated interrupt line. The event bits of the remaining pins are merged onto one shared interrupt line. An alternate-function word is stored for use by neighbouring logic. Reads are combinational from the current address. Writes take effect at the next rising clock edge.

Top module: `gpio_edge_ctl`

## Requirements
- R1: After synchronous reset, direction, output latch, both edge-enable words, event status and alternate-function word all read as zero. `pin_oe`, `pin_out` and every interrupt output are low.
- R2: A write to offset 0x08 sets each latch bit whose data bit is 1 and leaves the other latch bits alone. `pin_out` follows the latch. A read of offset 0x08 returns the latch.
- R3: A write to offset 0x0C clears each latch bit whose data bit is 1 and leaves the other latch bits alone. A read of offset 0x0C returns the latch.
- R4: Offset 0x04 holds the direction word, where 1 means output. `pin_oe` equals it bit for bit.
- R5: A read of offset 0x00 returns `pin_in` as seen through a two-stage synchronizer, two clock edges after the pin changes. Writes to offset 0x00 change nothing.
- R6: When bit n of the rising-enable word (offset 0x10) is set, a 0-to-1 change of pin n sets bit n of the event word (offset 0x18). When the enable bit is clear, the change records nothing.
- R7: When bit n of the falling-enable word (offset 0x14) is set, a 1-to-0 change of pin n sets event bit n. With both enables set, either direction records an event.
- R8: An event bit stays set until software writes 1 to it at offset 0x18. Zero data bits leave their event bits unchanged. Writing all ones clears every event.
- R9: If a new enabled edge on pin n arrives in the same cycle as a write that clears event bit n, the bit ends set.
- R10: `irq_pin[n]` equals event bit n for pins 0 to 10. `irq_shared` is the OR of event bits 11 to 27.
- R11: Offset 0x1C stores a 28-bit alternate-function word. Bits 31 to 28 of every register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register, word aligned |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 28 | Asynchronous pin levels |
| pin_out | output | 28 | Output latch |
| pin_oe | output | 28 | Output enable per pin |
| irq_pin | output | 11 | Dedicated interrupts for pins 0 to 10 |
| irq_shared | output | 1 | Combined interrupt for pins 11 to 27 |

## Verification
The assertions assume the bus is driven with known values whenever reset is low, and that `bus_addr` is always word aligned, because they decode only address bits 4 to 2. They also assume that nothing other than an acknowledge write lowers an event bit. The bench keeps to these assumptions. It changes the bus and the pins only at falling clock edges, holds the write strobe for a single cycle, and uses aligned offsets only. For the collision case it places the acknowledge write exactly on the edge at which the synchronized transition reaches the event register.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    // word select taken from address bits [4:2]
    typedef enum logic [2:0] {
        SEL_LEVEL = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_SET   = 3'd2,
        SEL_CLR   = 3'd3,
        SEL_REN   = 3'd4,
        SEL_FEN   = 3'd5,
        SEL_ACK   = 3'd6,
        SEL_ALT   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic dir;
        logic set;
        logic clr;
        logic ren;
        logic fen;
        logic ack;
        logic alt;
    } wr_strobe_t;

    function automatic reg_sel_e addr_to_sel(input logic [ADDR_W-1:0] addr);
        return reg_sel_e'(addr[4:2]);
    endfunction

    function automatic wr_strobe_t decode_wr(input logic we, input reg_sel_e sel);
        wr_strobe_t s;
        s     = '0;
        s.dir = we && (sel == SEL_DIR);
        s.set = we && (sel == SEL_SET);
        s.clr = we && (sel == SEL_CLR);
        s.ren = we && (sel == SEL_REN);
        s.fen = we && (sel == SEL_FEN);
        s.ack = we && (sel == SEL_ACK);
        s.alt = we && (sel == SEL_ALT);
        return s;
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int NPINS = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       wr,
    input  logic [NPINS-1:0] wd,
    input  logic [NPINS-1:0] rise,
    input  logic [NPINS-1:0] fall,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] latch_q,
    output logic [NPINS-1:0] ren_q,
    output logic [NPINS-1:0] fen_q,
    output logic [NPINS-1:0] status_q,
    output logic [NPINS-1:0] alt_q
);
    logic [NPINS-1:0] hits;
    logic [NPINS-1:0] ack_mask;
    logic [NPINS-1:0] latch_d;

    assign hits     = (rise & ren_q) | (fall & fen_q);
    assign ack_mask = wr.ack ? wd : '0;

    always_comb begin
        latch_d = latch_q;
        if (wr.set) latch_d = latch_q | wd;
        if (wr.clr) latch_d = latch_d & ~wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= '0;
            latch_q  <= '0;
            ren_q    <= '0;
            fen_q    <= '0;
            status_q <= '0;
            alt_q    <= '0;
        end else begin
            if (wr.dir) dir_q <= wd;
            if (wr.ren) ren_q <= wd;
            if (wr.fen) fen_q <= wd;
            if (wr.alt) alt_q <= wd;
            latch_q  <= latch_d;
            // new events win over a simultaneous acknowledge
            status_q <= (status_q & ~ack_mask) | hits;
        end
    end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int NPINS  = 28,
    parameter int NDEDIC = 11
) (
    input  logic [NPINS-1:0]  status,
    output logic [NDEDIC-1:0] irq_pin,
    output logic              irq_shared
);
    localparam int NSHARED = NPINS - NDEDIC;

    for (genvar i = 0; i < NDEDIC; i++) begin : g_dedic
        assign irq_pin[i] = status[i];
    end

    if (NSHARED > 0) begin : g_shared
        assign irq_shared = |status[NPINS-1:NDEDIC];
    end else begin : g_noshared
        assign irq_shared = 1'b0;
    end
endmodule

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl
    import gpio_edge_pkg::*;
#(
    parameter int NPINS  = 28,
    parameter int NDEDIC = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic [NDEDIC-1:0]    irq_pin,
    output logic                 irq_shared
);
    reg_sel_e         sel;
    wr_strobe_t       wr;
    logic [NPINS-1:0] level, rise, fall;
    logic [NPINS-1:0] dir_q, latch_q, ren_q, fen_q, status_q, alt_q;
    logic [NPINS-1:0] rd_word;

    assign sel = addr_to_sel(bus_addr);
    assign wr  = decode_wr(bus_we, sel);

    gpio_edge_sync #(.WIDTH(NPINS)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (pin_in),
        .level (level),
        .rise  (rise),
        .fall  (fall)
    );

    gpio_edge_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .wd       (bus_wdata[NPINS-1:0]),
        .rise     (rise),
        .fall     (fall),
        .dir_q    (dir_q),
        .latch_q  (latch_q),
        .ren_q    (ren_q),
        .fen_q    (fen_q),
        .status_q (status_q),
        .alt_q    (alt_q)
    );

    gpio_edge_irq #(.NPINS(NPINS), .NDEDIC(NDEDIC)) u_irq (
        .status     (status_q),
        .irq_pin    (irq_pin),
        .irq_shared (irq_shared)
    );

    always_comb begin
        unique case (sel)
            SEL_LEVEL:        rd_word = level;
            SEL_DIR:          rd_word = dir_q;
            SEL_SET, SEL_CLR: rd_word = latch_q;
            SEL_REN:          rd_word = ren_q;
            SEL_FEN:          rd_word = fen_q;
            SEL_ACK:          rd_word = status_q;
            SEL_ALT:          rd_word = alt_q;
            default:          rd_word = '0;
        endcase
    end

    assign bus_rdata = DATA_W'(rd_word);
    assign pin_out   = latch_q;
    assign pin_oe    = dir_q;
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
    import gpio_edge_pkg::*;
#(
    parameter int NPINS  = 28,
    parameter int NDEDIC = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NDEDIC-1:0] irq_pin
);
    logic wr_set, wr_clr, wr_dir, wr_ack;
    assign wr_set = bus_we && (bus_addr[4:2] == 3'(SEL_SET));
    assign wr_clr = bus_we && (bus_addr[4:2] == 3'(SEL_CLR));
    assign wr_dir = bus_we && (bus_addr[4:2] == 3'(SEL_DIR));
    assign wr_ack = bus_we && (bus_addr[4:2] == 3'(SEL_ACK));

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && irq_pin == '0));

    a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_set && !wr_clr) |=>
            ((pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    a_r3_clear_bits: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));

    a_r4_dir_load: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));

    a_r4_dir_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(pin_oe));

    a_r8_sticky_events: assert property (@(posedge clk) disable iff (rst)
        !wr_ack |=> ((irq_pin & $past(irq_pin)) == $past(irq_pin)));

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NPINS] == '0);
endmodule

bind gpio_edge_ctl gpio_edge_chk #(.NPINS(NPINS), .NDEDIC(NDEDIC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_pin   (irq_pin)
);

// File: tb/gpio_edge_ctl_test.sv
`timescale 1ns/1ps
module gpio_edge_ctl_test;
    localparam logic [4:0] A_LVL = 5'h00, A_DIR = 5'h04, A_SET = 5'h08, A_CLR = 5'h0C,
                           A_REN = 5'h10, A_FEN = 5'h14, A_EVT = 5'h18, A_ALT = 5'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [27:0] pin_in = '0;
    logic [27:0] pin_out, pin_oe;
    logic [10:0] irq_pin;
    logic        irq_shared;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_ctl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin(irq_pin), .irq_shared(irq_shared)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pins(input logic [27:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        foreach (d[i]) d[i] = 1'b0;
        for (int k = 1; k < 8; k++) begin
            rd(5'(k * 4), d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 reset oe/out", {4'h0, pin_oe | pin_out}, 32'h0);
        check("R1 reset irqs", {20'h0, irq_shared, irq_pin}, 32'h0);
    endtask

    task automatic t_latch;
        logic [31:0] d;
        wr(A_SET, 32'h0000_00A5);
        rd(A_SET, d);
        check("R2 set read", d, 32'h0000_00A5);
        check("R2 pin_out", {4'h0, pin_out}, 32'h0000_00A5);
        wr(A_SET, 32'h0800_0100);
        check("R2 set keeps others", {4'h0, pin_out}, 32'h0800_01A5);
        wr(A_CLR, 32'h0000_0021);
        rd(A_CLR, d);
        check("R3 clear read", d, 32'h0800_0184);
        wr(A_SET, 32'hF000_0000);
        rd(A_SET, d);
        check("R11 upper bits zero", d, 32'h0800_0184);
    endtask

    task automatic t_dir_alt;
        logic [31:0] d;
        wr(A_DIR, 32'hFF0F_0F0F);
        check("R4 oe equals dir", {4'h0, pin_oe}, 32'h0F0F_0F0F);
        rd(A_DIR, d);
        check("R4 dir read", d, 32'h0F0F_0F0F);
        wr(A_ALT, 32'h0ABC_DEF1);
        rd(A_ALT, d);
        check("R11 alt store", d, 32'h0ABC_DEF1);
    endtask

    task automatic t_level;
        logic [31:0] d;
        @(negedge clk);
        pin_in = 28'h5A5_A5A5;
        bus_addr = A_LVL;
        @(negedge clk);
        #1 check("R5 one edge not yet", bus_rdata, 32'h0);
        @(negedge clk);
        #1 check("R5 level after two edges", bus_rdata, 32'h05A5_A5A5);
        wr(A_LVL, 32'hFFFF_FFFF);
        rd(A_LVL, d);
        check("R5 level write ignored", d, 32'h05A5_A5A5);
        pins(28'h0);
        rd(A_EVT, d);
        check("R6 no event when disabled", d, 32'h0);
    endtask

    task automatic t_edges;
        logic [31:0] d;
        wr(A_REN, 32'h0000_1001);
        wr(A_FEN, 32'h0000_0028);
        pins(28'h000_0001);
        rd(A_EVT, d);
        check("R6 rising pin0", d, 32'h1);
        check("R10 irq pin0", {20'h0, irq_shared, irq_pin}, 32'h1);
        wr(A_EVT, 32'h1);
        pins(28'h0);
        rd(A_EVT, d);
        check("R6 falling ignored on rise-only pin", d, 32'h0);
        pins(28'h000_1008);
        rd(A_EVT, d);
        check("R6 rising pin12 only", d, 32'h0000_1000);
        check("R10 shared irq", {20'h0, irq_shared, irq_pin}, 32'h800);
        pins(28'h000_1000);
        rd(A_EVT, d);
        check("R7 falling pin3", d, 32'h0000_1008);
        check("R10 irq pin3 and shared", {20'h0, irq_shared, irq_pin}, 32'h808);
        wr(A_EVT, 32'h0000_0008);
        rd(A_EVT, d);
        check("R8 partial ack", d, 32'h0000_1000);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd(A_EVT, d);
        check("R8 clear all", d, 32'h0);
        check("R8 irqs low", {20'h0, irq_shared, irq_pin}, 32'h0);
        wr(A_REN, 32'h0000_0020);
        pins(28'h000_1020);
        rd(A_EVT, d);
        check("R7 both enabled rise", d, 32'h0000_0020);
        wr(A_EVT, 32'h20);
        pins(28'h000_1000);
        rd(A_EVT, d);
        check("R7 both enabled fall", d, 32'h0000_0020);
        repeat (4) @(negedge clk);
        rd(A_EVT, d);
        check("R8 sticky without ack", d, 32'h0000_0020);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        // pin5 event is pending; its next edge meets an acknowledge
        @(negedge clk);
        pin_in = 28'h000_1020;
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_EVT; bus_wdata = 32'h20; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_EVT, d);
        check("R9 edge wins over ack", d, 32'h0000_0020);
        wr(A_EVT, 32'h20);
        rd(A_EVT, d);
        check("R9 later ack clears", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latch();
        t_dir_alt();
        t_level();
        t_edges();
        t_collision();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule